// File: doc/BRIEF.md
# Endpoint Handshake Decision Unit

This block sits between a packet receiver and the endpoint buffers of a device-side USB function. It keeps one eight-bit control byte per endpoint. A processor reaches these bytes through a two-address register bus. Address 0 holds an endpoint index. Address 1 is a window onto the control byte of whichever endpoint the index selects.

When the receiver reports a token, the block looks up the control byte of the addressed endpoint together with that endpoint's setup-pending flag. From these it chooses the handshake to return: none, ACK, NAK or STALL. It also decides whether the data that came with the token may be written into the receive FIFO.

The decision is registered. Both outputs appear in the cycle after the token strobe and fall back to idle when no token is present. The endpoint count is a parameter. Endpoint 0 is always a control endpoint.

Top module: `ep_handshake`

## Requirements
- R1: After reset the index reads 0. Endpoint 0's control byte reads 0x25. Every other endpoint's control byte reads 0x00. Both outputs are idle (handshake 0, write-enable 0).
- R2: The bus decodes as follows. A write with bus_addr=0 loads the index from the low bits of the data, and a read returns it zero-extended. With bus_addr=1, reads and writes act on the selected endpoint only. Control byte layout: bit7 rx-stall, bit6 tx-stall, bit5 control-endpoint, bit4 reserved (always reads 0, writes ignored), bit3 rx-input-enable, bit2 rx-enable, bit1 tx-output-enable, bit0 tx-enable.
- R3: Bit 5 of endpoint 0 always reads 1, whatever is written.
- R4: For an OUT token (type 0) on an rx-enabled endpoint with pkt_ok high and rx-stall set, the response is STALL (3) if the endpoint's setup_pend bit is 0 and NAK (2) if it is 1. No FIFO write occurs.
- R5: For an IN token (type 1) on a tx-enabled endpoint with tx-stall set, the response is STALL when setup_pend is 0 and NAK when it is 1.
- R6: For an OUT token that is accepted and not stalled, the response is NAK with no FIFO write when rx-input-enable is 0. It is ACK (1) with fifo_we=1 when rx-input-enable is 1.
- R7: For an IN token on a tx-enabled endpoint that is not stalled, the response is NAK when tx-output-enable is 0 and ACK when it is 1. An IN token never raises fifo_we, and pkt_ok has no effect on it.
- R8: A SETUP token (type 2) with pkt_ok high on an endpoint whose bit 5 is 1 gets ACK and fifo_we=1. This holds regardless of rx-stall, rx-input-enable, rx-enable and setup_pend.
- R9: A SETUP token on an endpoint whose bit 5 is 0 gets no handshake (0) and no FIFO write.
- R10: An OUT token on an endpoint with rx-enable 0, or an IN token on an endpoint with tx-enable 0, gets no handshake and no FIFO write.
- R11: An OUT or SETUP token with pkt_ok low gets no handshake and no FIFO write.
- R12: The outputs reflect the token sampled at the previous rising edge. With no token, or with token type 3, they are handshake 0 and fifo_we 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = index register, 1 = selected control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tok_valid | input | 1 | Token strobe, one cycle per token |
| tok_type | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 unused |
| tok_ep | input | $clog2(NUM_EP) | Endpoint addressed by the token |
| pkt_ok | input | 1 | Data packet of an OUT/SETUP arrived intact |
| setup_pend | input | NUM_EP | Per-endpoint setup-pending flags |
| hs_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| fifo_we | output | 1 | Commit received data to the receive FIFO |

## Verification
Each endpoint is loaded with all 256 control byte values in turn. Against each value, every combination of token type, pkt_ok and setup-pending flag is applied, so each branch of the priority order is reached from every other bit setting. Opposite pending flags on the unaddressed endpoints show that the flag comes from the addressed endpoint. The same sweep also separates the effects of stall, enable and input-enable from each other, and it shows whether SETUP really bypasses them. Readback after every write exposes the reserved and hard-wired bits, and a final readback of all endpoints catches writes that land on the wrong endpoint.

// File: rtl/ep_hs_pkg.sv
`timescale 1ns/1ps
package ep_hs_pkg;

   typedef enum logic [1:0] {
      TOK_OUT   = 2'd0,
      TOK_IN    = 2'd1,
      TOK_SETUP = 2'd2,
      TOK_RSVD  = 2'd3
   } tok_e;

   typedef enum logic [1:0] {
      HS_NONE  = 2'd0,
      HS_ACK   = 2'd1,
      HS_NAK   = 2'd2,
      HS_STALL = 2'd3
   } hs_e;

   // control byte, MSB first
   typedef struct packed {
      logic rx_stall;
      logic tx_stall;
      logic ctl_ep;
      logic rsvd;
      logic rx_in_en;
      logic rx_ep_en;
      logic tx_out_en;
      logic tx_ep_en;
   } epctl_t;

   localparam int CTL_W = 8;
   localparam epctl_t EP0_RST  = 8'h25;
   localparam epctl_t EPN_RST  = 8'h00;

   function automatic epctl_t ctl_clean(input logic [CTL_W-1:0] w, input logic fixed_ctl);
      epctl_t t;
      t = epctl_t'(w);
      t.rsvd = 1'b0;
      if (fixed_ctl) t.ctl_ep = 1'b1;
      return t;
   endfunction

endpackage

// File: rtl/ep_hs_regbank.sv
`timescale 1ns/1ps
module ep_hs_regbank
   import ep_hs_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int IDXW   = $clog2(NUM_EP)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_we,
   input  logic                     bus_addr,
   input  logic [CTL_W-1:0]         bus_wdata,
   output logic [CTL_W-1:0]         bus_rdata,
   output logic [IDXW-1:0]          sel_idx,
   output epctl_t [NUM_EP-1:0]      ctl_q
);

   localparam int PADW = CTL_W - IDXW;

   logic idx_wr;
   logic ctl_wr;

   assign idx_wr = bus_we && !bus_addr;
   assign ctl_wr = bus_we &&  bus_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_idx <= '0;
      else if (idx_wr) sel_idx <= bus_wdata[IDXW-1:0];
   end

   for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      logic hit;
      assign hit = ctl_wr && (sel_idx == IDXW'(g));
      if (g == 0) begin : g_fixed
         // endpoint 0: control bit hard-wired through ctl_clean
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ctl_q[g] <= EP0_RST;
            else if (hit) ctl_q[g] <= ctl_clean(bus_wdata, 1'b1);
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ctl_q[g] <= EPN_RST;
            else if (hit) ctl_q[g] <= ctl_clean(bus_wdata, 1'b0);
         end
      end
   end

   always_comb begin
      if (bus_addr) bus_rdata = ctl_q[sel_idx];
      else          bus_rdata = {{PADW{1'b0}}, sel_idx};
   end

endmodule

// File: rtl/ep_hs_lookup.sv
`timescale 1ns/1ps
module ep_hs_lookup
   import ep_hs_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int IDXW   = $clog2(NUM_EP)
) (
   input  epctl_t [NUM_EP-1:0] ctl_q,
   input  logic [NUM_EP-1:0]   setup_pend,
   input  logic [IDXW-1:0]     tok_ep,
   output epctl_t              tok_ctl,
   output logic                tok_pend
);

   assign tok_ctl  = ctl_q[tok_ep];
   assign tok_pend = setup_pend[tok_ep];

endmodule

// File: rtl/ep_hs_decide.sv
`timescale 1ns/1ps
module ep_hs_decide
   import ep_hs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_valid,
   input  logic [1:0] tok_type,
   input  logic       pkt_ok,
   input  epctl_t     tok_ctl,
   input  logic       tok_pend,
   output logic [1:0] hs_code,
   output logic       fifo_we
);

   hs_e  hs_n;
   logic fw_n;

   always_comb begin
      hs_n = HS_NONE;
      fw_n = 1'b0;
      if (tok_valid) begin
         unique case (tok_e'(tok_type))
            TOK_OUT: begin
               if (tok_ctl.rx_ep_en && pkt_ok) begin
                  if (tok_ctl.rx_stall)       hs_n = tok_pend ? HS_NAK : HS_STALL;
                  else if (!tok_ctl.rx_in_en) hs_n = HS_NAK;
                  else begin
                     hs_n = HS_ACK;
                     fw_n = 1'b1;
                  end
               end
            end
            TOK_IN: begin
               if (tok_ctl.tx_ep_en) begin
                  if (tok_ctl.tx_stall)        hs_n = tok_pend ? HS_NAK : HS_STALL;
                  else if (!tok_ctl.tx_out_en) hs_n = HS_NAK;
                  else                         hs_n = HS_ACK;
               end
            end
            TOK_SETUP: begin
               if (tok_ctl.ctl_ep && pkt_ok) begin
                  hs_n = HS_ACK;
                  fw_n = 1'b1;
               end
            end
            default: begin
               hs_n = HS_NONE;
               fw_n = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_code <= HS_NONE;
         fifo_we <= 1'b0;
      end else begin
         hs_code <= hs_n;
         fifo_we <= fw_n;
      end
   end

endmodule

// File: rtl/ep_handshake.sv
`timescale 1ns/1ps
module ep_handshake
   import ep_hs_pkg::*;
#(
   parameter int NUM_EP = 4,
   localparam int IDXW  = $clog2(NUM_EP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              tok_valid,
   input  logic [1:0]        tok_type,
   input  logic [IDXW-1:0]   tok_ep,
   input  logic              pkt_ok,
   input  logic [NUM_EP-1:0] setup_pend,
   output logic [1:0]        hs_code,
   output logic              fifo_we
);

   if (NUM_EP < 2 || NUM_EP > 16 || (NUM_EP & (NUM_EP - 1)) != 0) begin : g_bad_cfg
      $error("ep_handshake: NUM_EP must be a power of two in 2..16");
   end

   logic [IDXW-1:0]     sel_idx;
   epctl_t [NUM_EP-1:0] ctl_q;
   epctl_t              tok_ctl;
   logic                tok_pend;

   ep_hs_regbank #(.NUM_EP(NUM_EP), .IDXW(IDXW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sel_idx   (sel_idx),
      .ctl_q     (ctl_q)
   );

   ep_hs_lookup #(.NUM_EP(NUM_EP), .IDXW(IDXW)) u_look (
      .ctl_q      (ctl_q),
      .setup_pend (setup_pend),
      .tok_ep     (tok_ep),
      .tok_ctl    (tok_ctl),
      .tok_pend   (tok_pend)
   );

   ep_hs_decide u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .tok_valid (tok_valid),
      .tok_type  (tok_type),
      .pkt_ok    (pkt_ok),
      .tok_ctl   (tok_ctl),
      .tok_pend  (tok_pend),
      .hs_code   (hs_code),
      .fifo_we   (fifo_we)
   );

endmodule

// File: rtl/ep_handshake_chk.sv
`timescale 1ns/1ps
module ep_handshake_chk #(
   parameter int IDXW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_addr,
   input logic [7:0]      bus_rdata,
   input logic [IDXW-1:0] sel_idx,
   input logic            tok_valid,
   input logic [1:0]      tok_type,
   input logic            pkt_ok,
   input logic [7:0]      tok_ctl,
   input logic            tok_pend,
   input logic [1:0]      hs_code,
   input logic            fifo_we
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(tok_valid) |-> (hs_code == 2'd0 && !fifo_we)); // R12

   AST_WRITE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we |-> hs_code == 2'd1); // R6

   AST_IN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(tok_valid && tok_type == 2'd1) |-> !fifo_we); // R7

   AST_SETUP_NONCTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(tok_valid && tok_type == 2'd2 && !tok_ctl[5]) |-> (hs_code == 2'd0 && !fifo_we)); // R9

   AST_SETUP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(tok_valid && tok_type == 2'd2 && tok_ctl[5] && pkt_ok) |-> (hs_code == 2'd1 && fifo_we)); // R8

   AST_PENDING_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(tok_valid && tok_pend) |-> hs_code != 2'd3); // R4

   AST_EP0_CTL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr && sel_idx == '0) |-> bus_rdata[5]); // R3

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr |-> !bus_rdata[4]); // R2

endmodule

bind ep_handshake ep_handshake_chk #(.IDXW(IDXW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .sel_idx   (sel_idx),
   .tok_valid (tok_valid),
   .tok_type  (tok_type),
   .pkt_ok    (pkt_ok),
   .tok_ctl   (tok_ctl),
   .tok_pend  (tok_pend),
   .hs_code   (hs_code),
   .fifo_we   (fifo_we)
);

// File: tb/ep_handshake_bench.sv
`timescale 1ns/1ps
module ep_handshake_bench;

   localparam int NEP  = 4;
   localparam int IW   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic          bus_addr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          tok_valid = 1'b0;
   logic [1:0]    tok_type = '0;
   logic [IW-1:0] tok_ep = '0;
   logic          pkt_ok = 1'b0;
   logic [NEP-1:0] setup_pend = '0;
   logic [1:0]    hs_code;
   logic          fifo_we;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ep_handshake #(.NUM_EP(NEP)) u_ep_handshake (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tok_valid(tok_valid),
      .tok_type(tok_type), .tok_ep(tok_ep), .pkt_ok(pkt_ok),
      .setup_pend(setup_pend), .hs_code(hs_code), .fifo_we(fifo_we)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // expected {hs, fifo_we} from the requirements
   function automatic logic [2:0] model(input logic [7:0] c, input bit pend,
                                         input bit ok, input int typ);
      logic [1:0] h;
      logic       w;
      h = 2'd0; w = 1'b0;
      case (typ)
         0: if (c[2] && ok) begin
               if (c[7])       h = pend ? 2'd2 : 2'd3;
               else if (!c[3]) h = 2'd2;
               else begin h = 2'd1; w = 1'b1; end
            end
         1: if (c[0]) begin
               if (c[6])       h = pend ? 2'd2 : 2'd3;
               else if (!c[1]) h = 2'd2;
               else            h = 2'd1;
            end
         2: if (c[5] && ok) begin h = 2'd1; w = 1'b1; end
         default: ;
      endcase
      return {h, w};
   endfunction

   function automatic string tag(input logic [7:0] c, input bit ok, input int typ);
      case (typ)
         0: return !c[2] ? "R10" : (!ok ? "R11" : (c[7] ? "R4" : "R6"));
         1: return !c[0] ? "R10" : (c[6] ? "R5" : "R7");
         2: return !c[5] ? "R9" : (!ok ? "R11" : "R8");
         default: return "R12";
      endcase
   endfunction

   task automatic token(input int ep, input int typ, input bit pend, input bit ok,
                        input logic [7:0] c);
      logic [2:0] e;
      string t;
      e = model(c, pend, ok, typ);
      t = tag(c, ok, typ);
      @(negedge clk);
      tok_valid = 1'b1; tok_type = 2'(typ); tok_ep = IW'(ep); pkt_ok = ok;
      setup_pend = pend ? NEP'(1 << ep) : ~NEP'(1 << ep);
      @(negedge clk);
      tok_valid = 1'b0;
      check({t, " handshake"}, hs_code, e[2:1]);
      check({t, " fifo write"}, fifo_we, e[0]);
      @(negedge clk);
      check("R12 idle after token", {hs_code, fifo_we}, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      logic [7:0] eff;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 handshake at reset", hs_code, 0);
      check("R1 fifo_we at reset", fifo_we, 0);
      bus_read(1'b0, rd); check("R1 index at reset", rd, 0);
      bus_read(1'b1, rd); check("R1 ep0 ctl at reset", rd, 8'h25);
      for (int e = 1; e < NEP; e++) begin
         bus_write(1'b0, 8'(e));
         bus_read(1'b1, rd); check("R1 epN ctl at reset", rd, 0);
      end
      bus_write(1'b0, 8'hFE);
      bus_read(1'b0, rd); check("R2 index keeps low bits", rd, 8'h02);

      // R12 unused token type with everything enabled
      bus_write(1'b0, 8'd1);
      bus_write(1'b1, 8'hFF);
      token(1, 3, 1'b0, 1'b1, 8'hEF);

      // full sweep
      for (int e = 0; e < NEP; e++) begin
         bus_write(1'b0, 8'(e));
         for (int v = 0; v < 256; v++) begin
            bus_write(1'b1, 8'(v));
            eff = (8'(v) & 8'hEF) | ((e == 0) ? 8'h20 : 8'h00);
            bus_read(1'b1, rd);
            check((e == 0) ? "R3 ep0 readback" : "R2 readback", rd, eff);
            for (int typ = 0; typ < 4; typ++)
               for (int p = 0; p < 2; p++)
                  for (int k = 0; k < 2; k++)
                     token(e, typ, p[0], k[0], eff);
         end
         bus_write(1'b1, 8'h00);
      end

      // R2 writes landed only on the selected endpoint
      for (int e = 0; e < NEP; e++) begin
         bus_write(1'b0, 8'(e));
         bus_read(1'b1, rd);
         check("R2 final per-endpoint readback", rd, (e == 0) ? 8'h20 : 8'h00);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule